// File: doc/BRIEF.md
# FIFO-to-Scratchpad Increment Engine

This fabric-side controller drains words that host software has pushed into a FIFO. While idle it samples the FIFO's empty status every cycle. When a word is waiting it pops it with a single-cycle pulse and waits out the FIFO's two-cycle read latency. It then adds one to the word and writes the sum into the fabric port of a dual-port scratchpad, which the host reads through the other port.

After the sum has been stored, the engine writes a ready marker into a second scratchpad word and raises a ready output. It then waits for the host to acknowledge. While it waits it takes no further words from the FIFO, so one result cannot overwrite another before the host has seen it. On acknowledgement the engine writes zero to the marker word, drops the ready output and resumes polling.

Top module: `fifo_incr_engine`

## Requirements
- R1: After reset, `fifo_pop`, `sp_we` and `ready_flag` are all low, and they stay low while `fifo_empty` is high.
- R2: The engine raises `fifo_pop` only in the cycle after it has sampled `fifo_empty` low while idle.
- R3: Each word is popped by a pulse exactly one cycle wide. Two consecutive cycles never both have `fifo_pop` high, and each stored result corresponds to exactly one pop.
- R4: Read data is taken from `fifo_rdata` only in the second cycle after the pop cycle. Values present on `fifo_rdata` in any other cycle do not affect the result.
- R5: The stored result is the popped word plus one, modulo 2^DATA_W (so all ones wraps to 0). It is written with `sp_we` high at scratchpad address DATA_ADDR (default 0), three cycles after the pop cycle.
- R6: In the cycle after the data write, the engine writes the value 1 to address FLAG_ADDR (default 1). From the next cycle `ready_flag` is high.
- R7: While `ready_flag` is high, no word is popped, even when the FIFO holds data.
- R8: `host_ack` sampled high while `ready_flag` is high clears `ready_flag` at that edge. In the following cycle the engine writes 0 to FLAG_ADDR and then resumes polling.
- R9: `host_ack` while `ready_flag` is low has no effect: no pop, no write and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO has no word available |
| fifo_pop | output | 1 | Single-cycle read request to the FIFO |
| fifo_rdata | input | DATA_W | FIFO read data, valid two cycles after the pop |
| sp_we | output | 1 | Scratchpad write enable |
| sp_addr | output | ADDR_W | Scratchpad word address |
| sp_wdata | output | DATA_W | Scratchpad write data |
| ready_flag | output | 1 | Result present, awaiting host acknowledgement |
| host_ack | input | 1 | Host acknowledges the result |

## Verification
The assertions assume that the FIFO never reports empty low when it holds no data, and that `fifo_rdata` carries the popped word in the second cycle after the pop. The bench's FIFO model honours both. It keeps a real queue behind `fifo_empty` and drives a fixed poison pattern on `fifo_rdata` in every other cycle. The bench pulses `host_ack` for one cycle only, and only while the flag is raised, except for one deliberate idle pulse that checks the flag and the pop and write outputs stay inert.

// File: rtl/fifo_incr_engine.sv
module fifo_incr_engine #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] DATA_ADDR = '0,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              sp_we,
  output logic [ADDR_W-1:0] sp_addr,
  output logic [DATA_W-1:0] sp_wdata,
  output logic              ready_flag,
  input  logic              host_ack
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  typedef enum logic [2:0] {
    S_POLL, S_POP, S_LAT, S_CAP, S_WDATA, S_WFLAG, S_HOLD, S_CLR
  } state_t;

  state_t state;
  logic [DATA_W-1:0] result;
  logic              flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_POLL;
      result <= '0;
      flag_q <= 1'b0;
    end else begin
      case (state)
        S_POLL:  if (!fifo_empty) state <= S_POP;
        S_POP:   state <= S_LAT;
        S_LAT:   state <= S_CAP;
        S_CAP: begin
          result <= fifo_rdata + ONE;
          state  <= S_WDATA;
        end
        S_WDATA: state <= S_WFLAG;
        S_WFLAG: begin
          flag_q <= 1'b1;
          state  <= S_HOLD;
        end
        S_HOLD: if (host_ack) begin
          flag_q <= 1'b0;
          state  <= S_CLR;
        end
        S_CLR:   state <= S_POLL;
        default: state <= S_POLL;
      endcase
    end
  end

  assign fifo_pop   = (state == S_POP);
  assign sp_we      = (state == S_WDATA) || (state == S_WFLAG) || (state == S_CLR);
  assign sp_addr    = (state == S_WDATA) ? DATA_ADDR : FLAG_ADDR;
  assign sp_wdata   = (state == S_WDATA) ? result :
                      (state == S_WFLAG) ? ONE : '0;
  assign ready_flag = flag_q;

  p_pop_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |=> !fifo_pop);

  p_pop_after_nonempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_pop) |-> $past(!fifo_empty));

  p_no_pop_while_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_flag |-> !fifo_pop);

  p_incremented_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_we && sp_addr == DATA_ADDR && $past(sp_we) == 1'b0) |->
      sp_wdata == $past(fifo_rdata) + ONE);

  p_flag_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_flag && !host_ack) |=> ready_flag);

  p_flag_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready_flag) |-> $past(sp_we && sp_addr == FLAG_ADDR && sp_wdata == ONE));

  p_write_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sp_we |-> (sp_addr == DATA_ADDR || sp_addr == FLAG_ADDR));

endmodule

// File: tb/fifo_incr_engine_tb.sv
module fifo_incr_engine_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam logic [DW-1:0] POISON = 32'hA5A5_5A5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_empty, fifo_pop, sp_we, ready_flag;
  logic host_ack = 1'b0;
  logic [DW-1:0] fifo_rdata, sp_wdata;
  logic [AW-1:0] sp_addr;

  always #10 clk = ~clk;

  fifo_incr_engine #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata), .sp_we(sp_we), .sp_addr(sp_addr),
    .sp_wdata(sp_wdata), .ready_flag(ready_flag), .host_ack(host_ack));

  logic [DW-1:0] q [0:255];
  logic [7:0] head = '0, tail = '0;
  logic [DW-1:0] s1 = '0, s2 = '0;
  logic v1 = 1'b0, v2 = 1'b0;
  assign fifo_empty = (head == tail);
  assign fifo_rdata = v2 ? s2 : POISON;

  always @(posedge clk) begin
    v1 <= fifo_pop;
    v2 <= v1;
    s2 <= s1;
    if (fifo_pop) begin
      s1 <= q[head];
      head <= head + 8'd1;
    end
  end

  int cyc = 0, tests = 0, fails = 0, pops = 0, writes = 0;
  int pop_cyc = 0, wr_cyc = 0;
  logic prev_pop = 1'b0;
  logic [DW-1:0] mem [0:15];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_pop && prev_pop) begin
        fails++; $display("FAIL R3: pop high two cycles, got 1 expected 0");
      end
      if (fifo_pop) begin pops++; pop_cyc = cyc; end
      if (sp_we) begin
        writes++;
        mem[sp_addr] = sp_wdata;
        if (sp_addr == 0) wr_cyc = cyc;
      end
    end
    prev_pop = fifo_pop;
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] v);
    @(negedge clk);
    q[tail] = v;
    tail = tail + 8'd1;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 60 && !ready_flag; i++) @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    check("R8 flag cleared", {31'b0, ready_flag}, 32'd0);
    @(negedge clk);
    check("R8 marker zeroed", mem[1], 32'd0);
  endtask

  task automatic one_word(input logic [DW-1:0] v);
    int p0;
    p0 = pops;
    push(v);
    wait_flag();
    check("R6 flag raised", {31'b0, ready_flag}, 32'd1);
    check("R5 result", mem[0], v + 32'd1);
    check("R6 marker", mem[1], 32'd1);
    check("R3 one pop", pops - p0, 32'd1);
    check("R4/R5 latency", wr_cyc - pop_cyc, 32'd3);
    ack();
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 32'hFFFF_0000;
    repeat (3) @(negedge clk);
    check("R1 pop at reset", {31'b0, fifo_pop}, 0);
    check("R1 we at reset", {31'b0, sp_we}, 0);
    check("R1 flag at reset", {31'b0, ready_flag}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check("R1 idle no pop", pops, 0);
    check("R1 idle no write", writes, 0);
    @(negedge clk); host_ack = 1'b1;
    @(negedge clk); host_ack = 1'b0;
    repeat (4) @(negedge clk);
    check("R9 ack idle flag", {31'b0, ready_flag}, 0);
    check("R9 ack idle writes", writes, 0);
    check("R9 ack idle pops", pops, 0);

    for (int v = 0; v < 24; v++) one_word(32'(v * 32'h0111_1111));
    one_word(32'hFFFF_FFFF);
    one_word(32'h7FFF_FFFF);
    one_word(POISON);
    one_word(32'hFFFF_FFFE);

    push(32'd100);
    push(32'd200);
    wait_flag();
    repeat (20) @(negedge clk);
    check("R7 held pops", {24'b0, tail - head}, 32'd1);
    check("R7 held data", mem[0], 32'd101);
    check("R7 held flag", {31'b0, ready_flag}, 32'd1);
    ack();
    wait_flag();
    check("R2 second word", mem[0], 32'd201);
    ack();
    check("R3 total pops", pops, writes / 3);
    check("R2 fifo drained", {31'b0, fifo_empty}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule